// File: doc/BRIEF.md
# Asymmetric Dual-Issue Slot Arbiter

This block sits after decode in an in-order core with two unequal issue pipes. Each cycle it receives up to two instructions, an older one in slot 0 and a younger one in slot 1, each tagged with a 4-bit operation class. It decides for each slot whether the instruction issues this cycle and, if it does, on which pipe. It also reports the result latency of each class. Pipe 0 accepts every class. Pipe 1 accepts only a subset. Some classes need both pipes in the same cycle.

The arbiter also tracks the structural units that stay busy after issue. The non-pipelined divide/square-root unit is handled by a tracker FSM with states DV_IDLE and DV_BUSY. DV_IDLE goes to DV_BUSY when a divide-class instruction is granted, loading a class-specific hold count. DV_BUSY counts down once per cycle and returns to DV_IDLE when the count reaches its last cycle. The SIMD unit is handled by a tracker with states SM_IDLE and SM_TAIL. SM_IDLE goes to SM_TAIL when a 128-bit SIMD instruction is granted, and SM_TAIL always returns to SM_IDLE on the next cycle. The issue FSM has states ST_OPEN and ST_PAIR2. ST_OPEN goes to ST_PAIR2 when a 128-bit store pair is granted, and ST_PAIR2 always returns to ST_OPEN on the next cycle. All three FSMs return to their idle state on a synchronous reset.

Grant, pipe and latency outputs are combinational. They depend on the slot inputs and on the registered state of the three FSMs. The outputs are meant to drive the pipe selection logic in the same cycle.

Top module: `dsa_issue_arbiter`

## Requirements
- R1: A synchronous reset returns every tracker to idle. With no valid slot, both grants are 0. The first instruction presented after reset is not held back by any claim made before the reset.
- R2: When both slots hold classes that may use either pipe (0 and 1), both are granted. Slot 0 goes to pipe 0 and slot 1 goes to pipe 1. A pipe output of 0 means pipe 0 and 1 means pipe 1.
- R3: Load (8) and store (9) issue only on pipe 0. Multiply (2), all divide/sqrt classes (3 to 7), branch (10) and SIMD (14, 15) issue only on pipe 1. When slot 0 takes pipe 1 and slot 1 holds a class allowed on pipe 0, slot 1 is granted pipe 0.
- R4: Issue is in order. When slot 0 is not granted, slot 1 is not granted either.
- R5: When slot 1 needs the pipe that slot 0 has taken, or would claim the same busy unit, only slot 0 issues.
- R6: The dual-pipe classes (11, 12, 13) issue alone, reporting pipe 0. A dual-pipe class in slot 1 is never granted alongside slot 0.
- R7: In the cycle after a class-13 instruction (128-bit store pair) is granted, neither slot is granted.
- R8: After an integer divide (3) is granted, every divide-class request is refused for the next 21 cycles. A request in the 22nd cycle after issue is granted.
- R9: After a divide or square-root grant, the unit stays closed for a number of cycles that depends on the class: 8 for single divide (4), 18 for double divide (5), 13 for single sqrt (6) and 27 for double sqrt (7).
- R10: A 128-bit SIMD grant (15) refuses any SIMD class in the next cycle. A 64-bit SIMD grant (14) does not.
- R11: The latency output for each valid slot equals the latency of its class. The latencies are: 0:1, 1:2, 2:4, 3:22, 4:12, 5:22, 6:17, 7:31, 8:3, 9:1, 10:1, 11:1, 12:4, 13:2, 14:4, 15:5.
- R12: A busy divide unit does not hold back classes that do not use it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s0_valid | input | 1 | Older slot holds an instruction |
| s0_cls | input | 4 | Older slot operation class |
| s1_valid | input | 1 | Younger slot holds an instruction |
| s1_cls | input | 4 | Younger slot operation class |
| s0_grant | output | 1 | Older slot issues this cycle |
| s0_pipe | output | 1 | Pipe for the older slot |
| s0_lat | output | 6 | Result latency of the older slot class |
| s1_grant | output | 1 | Younger slot issues this cycle |
| s1_pipe | output | 1 | Pipe for the younger slot |
| s1_lat | output | 6 | Result latency of the younger slot class |

## Verification
Three functions can fall in the same cycle: refusal by a busy unit, the pipe choice between the two slots, and the in-order rule. The bench provokes this by putting a divide or SIMD class in slot 0 while its unit is still busy and a flexible class in slot 1. Slot 1 must then be refused even though a pipe is free. It also puts a non-divide class in slot 0 during a divide hold, so that pipe selection must proceed while the refusal logic is active. Each cycle is judged against a behavioural model that keeps integer countdowns for the units and the store-pair hold.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
    localparam int CLS_W  = 4;
    localparam int LAT_W  = 6;
    localparam int HOLD_W = 5;

    typedef enum logic [CLS_W-1:0] {
        CL_ALU    = 4'd0,
        CL_ALU2   = 4'd1,
        CL_MUL    = 4'd2,
        CL_IDIV   = 4'd3,
        CL_FDIVS  = 4'd4,
        CL_FDIVD  = 4'd5,
        CL_FSQRTS = 4'd6,
        CL_FSQRTD = 4'd7,
        CL_LOAD   = 4'd8,
        CL_STORE  = 4'd9,
        CL_BRANCH = 4'd10,
        CL_PAIR   = 4'd11,
        CL_LDPQ   = 4'd12,
        CL_STPQ   = 4'd13,
        CL_V64    = 4'd14,
        CL_V128   = 4'd15
    } op_class_t;

    typedef struct packed {
        logic              p0_ok;
        logic              p1_ok;
        logic              both;
        logic              div;
        logic [HOLD_W-1:0] div_hold;
        logic              simd;
        logic              simd_wide;
        logic              pair_two;
        logic [LAT_W-1:0]  lat;
    } cls_info_t;
endpackage

// File: rtl/dsa_class_decode.sv
module dsa_class_decode
    import dsa_pkg::*;
(
    input  op_class_t cls,
    output cls_info_t info
);
    always_comb begin
        info = '0;
        unique case (cls)
            CL_ALU:    begin info.p0_ok = 1'b1; info.p1_ok = 1'b1; info.lat = LAT_W'(1); end
            CL_ALU2:   begin info.p0_ok = 1'b1; info.p1_ok = 1'b1; info.lat = LAT_W'(2); end
            CL_MUL:    begin info.p1_ok = 1'b1; info.lat = LAT_W'(4); end
            CL_IDIV:   begin info.p1_ok = 1'b1; info.div = 1'b1; info.div_hold = HOLD_W'(21); info.lat = LAT_W'(22); end
            CL_FDIVS:  begin info.p1_ok = 1'b1; info.div = 1'b1; info.div_hold = HOLD_W'(8);  info.lat = LAT_W'(12); end
            CL_FDIVD:  begin info.p1_ok = 1'b1; info.div = 1'b1; info.div_hold = HOLD_W'(18); info.lat = LAT_W'(22); end
            CL_FSQRTS: begin info.p1_ok = 1'b1; info.div = 1'b1; info.div_hold = HOLD_W'(13); info.lat = LAT_W'(17); end
            CL_FSQRTD: begin info.p1_ok = 1'b1; info.div = 1'b1; info.div_hold = HOLD_W'(27); info.lat = LAT_W'(31); end
            CL_LOAD:   begin info.p0_ok = 1'b1; info.lat = LAT_W'(3); end
            CL_STORE:  begin info.p0_ok = 1'b1; info.lat = LAT_W'(1); end
            CL_BRANCH: begin info.p1_ok = 1'b1; info.lat = LAT_W'(1); end
            CL_PAIR:   begin info.p0_ok = 1'b1; info.p1_ok = 1'b1; info.both = 1'b1; info.lat = LAT_W'(1); end
            CL_LDPQ:   begin info.p0_ok = 1'b1; info.p1_ok = 1'b1; info.both = 1'b1; info.lat = LAT_W'(4); end
            CL_STPQ:   begin info.p0_ok = 1'b1; info.p1_ok = 1'b1; info.both = 1'b1; info.pair_two = 1'b1; info.lat = LAT_W'(2); end
            CL_V64:    begin info.p1_ok = 1'b1; info.simd = 1'b1; info.lat = LAT_W'(4); end
            CL_V128:   begin info.p1_ok = 1'b1; info.simd = 1'b1; info.simd_wide = 1'b1; info.lat = LAT_W'(5); end
            default:   info = '0;
        endcase
    end
endmodule

// File: rtl/dsa_div_tracker.sv
module dsa_div_tracker
    import dsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [HOLD_W-1:0] hold,
    output logic              busy
);
    typedef enum logic {DV_IDLE, DV_BUSY} dv_state_t;
    dv_state_t         state;
    logic [HOLD_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= DV_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                DV_IDLE: begin
                    if (start && hold != '0) begin
                        state <= DV_BUSY;
                        cnt   <= hold;
                    end
                end
                DV_BUSY: begin
                    if (cnt == HOLD_W'(1)) begin
                        state <= DV_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt - HOLD_W'(1);
                    end
                end
                default: state <= DV_IDLE;
            endcase
        end
    end

    always_comb busy = (state == DV_BUSY);

    // R8: no new divide claim may arrive while the unit is held
    p_no_claim_busy_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start);
    // R9: a held unit always has a live countdown
    p_count_live_r9: assert property (@(posedge clk) disable iff (rst)
        (state == DV_BUSY) |-> (cnt != '0));
endmodule

// File: rtl/dsa_simd_tracker.sv
module dsa_simd_tracker (
    input  logic clk,
    input  logic rst,
    input  logic claim,
    input  logic claim_wide,
    output logic busy
);
    typedef enum logic {SM_IDLE, SM_TAIL} sm_state_t;
    sm_state_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SM_IDLE;
        end else begin
            unique case (state)
                SM_IDLE: if (claim && claim_wide) state <= SM_TAIL;
                SM_TAIL: state <= SM_IDLE;
                default: state <= SM_IDLE;
            endcase
        end
    end

    always_comb busy = (state == SM_TAIL);

    // R10: the cycle after a wide claim carries no SIMD claim
    p_wide_gap_r10: assert property (@(posedge clk) disable iff (rst)
        (claim && claim_wide) |=> !claim);
endmodule

// File: rtl/dsa_issue_arbiter.sv
module dsa_issue_arbiter
    import dsa_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             s0_valid,
    input  logic [CLS_W-1:0] s0_cls,
    input  logic             s1_valid,
    input  logic [CLS_W-1:0] s1_cls,
    output logic             s0_grant,
    output logic             s0_pipe,
    output logic [LAT_W-1:0] s0_lat,
    output logic             s1_grant,
    output logic             s1_pipe,
    output logic [LAT_W-1:0] s1_lat
);
    localparam int NSLOT = 2;

    typedef enum logic {ST_OPEN, ST_PAIR2} is_state_t;
    is_state_t state;

    logic [CLS_W-1:0] slot_cls [NSLOT];
    cls_info_t        info     [NSLOT];

    assign slot_cls[0] = s0_cls;
    assign slot_cls[1] = s1_cls;

    for (genvar g = 0; g < NSLOT; g++) begin : g_dec
        dsa_class_decode u_dec (
            .cls  (op_class_t'(slot_cls[g])),
            .info (info[g])
        );
    end

    logic              div_busy, simd_busy;
    logic              div_start;
    logic [HOLD_W-1:0] div_hold;
    logic              simd_claim, simd_wide;
    logic              g0, g1, pipe0, pipe1, lane_ok;

    always_comb begin
        g0 = s0_valid && (state == ST_OPEN)
             && !(info[0].div && div_busy)
             && !(info[0].simd && simd_busy);
        pipe0 = !info[0].p0_ok;
        pipe1 = !pipe0;
        lane_ok = pipe0 ? info[1].p0_ok : info[1].p1_ok;
        g1 = g0 && s1_valid && lane_ok
             && !info[0].both && !info[1].both
             && !(info[1].div && (div_busy || info[0].div))
             && !(info[1].simd && (simd_busy || info[0].simd));
    end

    always_comb begin
        s0_grant = g0;
        s0_pipe  = pipe0;
        s0_lat   = info[0].lat;
        s1_grant = g1;
        s1_pipe  = pipe1;
        s1_lat   = info[1].lat;

        div_start  = (g0 && info[0].div) || (g1 && info[1].div);
        div_hold   = (g0 && info[0].div) ? info[0].div_hold : info[1].div_hold;
        simd_claim = (g0 && info[0].simd) || (g1 && info[1].simd);
        simd_wide  = (g0 && info[0].simd_wide) || (g1 && info[1].simd_wide);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OPEN;
        end else begin
            unique case (state)
                ST_OPEN:  if (g0 && info[0].pair_two) state <= ST_PAIR2;
                ST_PAIR2: state <= ST_OPEN;
                default:  state <= ST_OPEN;
            endcase
        end
    end

    dsa_div_tracker u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .hold  (div_hold),
        .busy  (div_busy)
    );

    dsa_simd_tracker u_simd (
        .clk        (clk),
        .rst        (rst),
        .claim      (simd_claim),
        .claim_wide (simd_wide),
        .busy       (simd_busy)
    );

    // R4: younger never issues without the older
    p_in_order_r4: assert property (@(posedge clk) disable iff (rst)
        s1_grant |-> s0_grant);
    // R5: two grants never share a pipe
    p_distinct_pipes_r5: assert property (@(posedge clk) disable iff (rst)
        (s0_grant && s1_grant) |-> (s0_pipe != s1_pipe));
    // R7: store pair keeps both pipes for a second cycle
    p_pair_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (s0_grant && s0_cls == CL_STPQ) |=> (!s0_grant && !s1_grant));
    // R3: memory access classes land on pipe 0
    p_mem_pipe0_r3: assert property (@(posedge clk) disable iff (rst)
        (s1_grant && (s1_cls == CL_LOAD || s1_cls == CL_STORE)) |-> !s1_pipe);
    // R6: dual-pipe class never shares its cycle
    p_alone_r6: assert property (@(posedge clk) disable iff (rst)
        (s0_grant && (s0_cls == CL_PAIR || s0_cls == CL_LDPQ || s0_cls == CL_STPQ)) |-> !s1_grant);
endmodule

// File: tb/dsa_issue_arbiter_tb.sv
module dsa_issue_arbiter_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       s0_valid = 1'b0, s1_valid = 1'b0;
    logic [3:0] s0_cls = '0, s1_cls = '0;
    logic       s0_grant, s0_pipe, s1_grant, s1_pipe;
    logic [5:0] s0_lat, s1_lat;

    int n_chk = 0, n_fail = 0;
    int m_div = 0, m_simd = 0, m_hold = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dsa_issue_arbiter dut_i (
        .clk(clk), .rst(rst),
        .s0_valid(s0_valid), .s0_cls(s0_cls),
        .s1_valid(s1_valid), .s1_cls(s1_cls),
        .s0_grant(s0_grant), .s0_pipe(s0_pipe), .s0_lat(s0_lat),
        .s1_grant(s1_grant), .s1_pipe(s1_pipe), .s1_lat(s1_lat)
    );

    // pipe mask: 1 pipe0 only, 2 pipe1 only, 3 either, 4 both at once
    function automatic int where_c(int c);
        if (c <= 1) return 3;
        if (c == 8 || c == 9) return 1;
        if (c >= 11 && c <= 13) return 4;
        return 2;
    endfunction
    function automatic int lat_c(int c);
        int t[16] = '{1,2,4,22,12,22,17,31,3,1,1,1,4,2,4,5};
        return t[c];
    endfunction
    function automatic int dhold_c(int c);
        case (c) 3: return 21; 4: return 8; 5: return 18; 6: return 13; 7: return 27; default: return 0; endcase
    endfunction
    function automatic bit vec_c(int c);
        return (c == 14 || c == 15);
    endfunction

    task automatic step(input bit v0, input int c0, input bit v1, input int c1, input string tag);
        bit eg0, eg1, ep0, ep1, ok;
        @(negedge clk);
        s0_valid = v0; s0_cls = 4'(c0); s1_valid = v1; s1_cls = 4'(c1);
        #2;
        eg0 = v0 && m_hold == 0 && !(dhold_c(c0) > 0 && m_div > 0) && !(vec_c(c0) && m_simd > 0);
        ep0 = (where_c(c0) == 2);
        ep1 = !ep0;
        eg1 = eg0 && v1 && where_c(c0) != 4 && where_c(c1) != 4
              && (ep0 ? (where_c(c1) & 1) != 0 : (where_c(c1) & 2) != 0)
              && !(dhold_c(c1) > 0 && (m_div > 0 || dhold_c(c0) > 0))
              && !(vec_c(c1) && (m_simd > 0 || vec_c(c0)));
        ok = (s0_grant === eg0) && (s1_grant === eg1)
             && (!eg0 || s0_pipe === ep0) && (!eg1 || s1_pipe === ep1)
             && (!v0 || s0_lat === 6'(lat_c(c0))) && (!v1 || s1_lat === 6'(lat_c(c1)));
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got g0=%b p0=%b l0=%0d g1=%b p1=%b l1=%0d exp g0=%b p0=%b l0=%0d g1=%b p1=%b l1=%0d",
                     tag, s0_grant, s0_pipe, s0_lat, s1_grant, s1_pipe, s1_lat,
                     eg0, ep0, lat_c(c0), eg1, ep1, lat_c(c1));
        end
        @(posedge clk);
        if (m_hold > 0) m_hold--;
        if (m_div > 0) m_div--;
        if (m_simd > 0) m_simd--;
        if (eg0 && c0 == 13) m_hold = 1;
        if (eg0 && dhold_c(c0) > 0) m_div = dhold_c(c0);
        if (eg1 && dhold_c(c1) > 0) m_div = dhold_c(c1);
        if ((eg0 && c0 == 15) || (eg1 && c1 == 15)) m_simd = 1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; s0_valid = 0; s1_valid = 0;
        @(posedge clk); @(posedge clk);
        #1 rst = 1'b0;
        m_div = 0; m_simd = 0; m_hold = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        do_reset();
        step(0, 0, 0, 0, "R1 idle after reset");
        step(1, 0, 1, 1, "R2 alu pair");
        step(1, 1, 1, 0, "R2 alu2 alu");
        for (int c = 0; c < 16; c++) step(1, c, 1, 15 - c, "R11 latency sweep");
        do_reset();
        step(1, 8, 1, 0, "R3 load then alu");
        step(1, 0, 1, 9, "R3 store younger blocked on pipe1");
        step(1, 10, 1, 0, "R3 branch older, alu to pipe0");
        step(1, 2, 1, 8, "R3 mul older, load to pipe0");
        step(1, 8, 1, 9, "R5 two pipe0 only");
        step(1, 2, 1, 10, "R5 two pipe1 only");
        step(1, 11, 1, 0, "R6 pair alone");
        step(1, 0, 1, 12, "R6 younger dual blocked");
        step(1, 12, 0, 0, "R6 ldpq alone");
        step(1, 13, 1, 0, "R6 stpq alone");
        step(1, 0, 1, 1, "R7 quiet after stpq");
        step(1, 0, 1, 1, "R7 reopen");
        step(1, 15, 1, 0, "R10 wide simd");
        step(1, 14, 1, 0, "R10 simd refused in tail, R4 younger blocked");
        step(1, 14, 0, 0, "R10 simd after tail");
        step(1, 14, 0, 0, "R10 narrow back to back");
        step(1, 0, 1, 15, "R10 wide in younger");
        step(1, 0, 1, 14, "R10 younger simd refused in tail");
        step(1, 3, 1, 0, "R8 idiv issue");
        for (int i = 0; i < 21; i++) step(1, 3, 1, 0, "R8 idiv held, R4 younger blocked");
        step(1, 3, 0, 0, "R8 idiv accepted");
        step(1, 8, 1, 0, "R12 load/alu during divide");
        step(1, 10, 1, 1, "R12 branch/alu during divide");
        step(1, 0, 1, 4, "R5 younger divide refused while busy");
        for (int c = 4; c <= 7; c++) begin
            for (int i = 0; i < 32; i++) step(1, c, 0, 0, "R9 fp divide/sqrt hold");
        end
        step(1, 3, 1, 5, "R5 two divides same cycle");
        step(1, 0, 0, 0, "R12 alu while busy");
        do_reset();
        step(1, 3, 0, 0, "R1 divide granted after reset");
        step(1, 1, 1, 0, "R1 alu pair after reset");
        done = 1;
        finish_run();
    end

    initial begin
        for (int k = 0; k < 20000; k++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            finish_run();
        end
    end
endmodule